// File: doc/BRIEF.md
# Pipelined Signed Array Multiplier

This block multiplies two signed two's-complement operands of `W` bits each and returns the `2W`-bit signed product. Internally it is a carry-save array of full-adder cells followed by a rippling carry-propagate chain. A register bank closes every adder row and every adder cell of the final chain, so the logic between any two flops is one full-adder level (plus an AND gate at the array rows). Operand sign is handled inside the array. Each partial product is sign-extended to the full product width. The row that belongs to the operand B sign bit is added in inverted form, and its `+1` is seeded into the carry vector of the first row.

A caller presents an operand pair together with a valid flag on any clock cycle, and may do so on every cycle with no stall. The matching product and its valid flag leave the block a fixed number of cycles later. Operand bits that later rows still need travel along the array in skew registers, so pairs that follow one another never mix. The default width is 8 bits, which gives 7 carry-save rows, 8 carry-propagate stages and one output register.

Top module: `mp_array_mult`

## Requirements
- R1: For every operand pair, `prod_o` equals the signed product of `a_i` and `b_i`, both read as two's complement, written as a `2W`-bit two's-complement value.
- R2: A pair sampled on a rising edge while `in_valid_i` is high appears on `prod_o`, with `out_valid_o` high, exactly `2W` clock cycles later. These cycles are `W-1` carry-save rows, `W` carry-propagate stages and one output register, so the default gives 16 cycles.
- R3: `out_valid_o` is `in_valid_i` delayed by exactly the same `2W` cycles: one output pulse for each input pulse, and none without one.
- R4: A new pair is accepted on every cycle with no stall. Back-to-back pairs each produce their own correct product, on consecutive cycles.
- R5: Reset is synchronous and active high. After a rising edge with `rst_i` high, `out_valid_o` is 0 and `prod_o` is all zeros. Both stay that way until the first pair sampled after reset reaches the output.
- R6: The extreme operands give the exact result. Most-negative times most-negative gives `+2^(2W-2)` (0x4000 for W=8). Most-negative times most-positive gives `-(2^(2W-2)-2^(W-1))`. Minus one times minus one gives 1. Any operand times zero gives 0.
- R7: Asserting reset while pairs are in flight discards all of them. No `out_valid_o` pulse and no non-zero `prod_o` value ever appears for a pair sampled before, or on, the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every register updates on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset that clears the whole pipeline |
| in_valid_i | input | 1 | High when `a_i`/`b_i` carry a pair to multiply |
| a_i | input | W | Multiplicand, signed two's complement |
| b_i | input | W | Multiplier, signed two's complement |
| out_valid_o | output | 1 | High when `prod_o` holds the product of a valid pair |
| prod_o | output | 2W | Signed product |

## Verification
The hardest situation to reach from the ports is a pipeline in which many different pairs sit in the array at once while a reset lands on them. This is the only case in which a skew-register slip or a missing clear in one stage shows up, either as a wrong product leaking out or as a flushed pair reappearing. The stimulus fills the array with back-to-back seeded random pairs, then asserts reset for two cycles and restarts streaming at once. Valid and product are then compared on every cycle while the flushed slots drain. Directed pairs at the most negative and most positive values, isolated single pulses and random gaps round out the sign-extension and latency cases.

// File: rtl/mp_pkg.sv
package mp_pkg;

    // Smallest operand width the array layout supports.
    localparam int unsigned MP_MIN_WIDTH = 3;

    // Carry-save rows after the seed row (one per remaining multiplier bit).
    function automatic int unsigned mp_csa_rows(input int unsigned w);
        return w - 1;
    endfunction

    // Carry-propagate stages, one per upper product bit.
    function automatic int unsigned mp_cpa_stages(input int unsigned w);
        return w;
    endfunction

    // Cycles from input sample to visible output, output register included.
    function automatic int unsigned mp_latency(input int unsigned w);
        return mp_csa_rows(w) + mp_cpa_stages(w) + 1;
    endfunction

endpackage

// File: rtl/mp_fa_cell.sv
module mp_fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic s_o,
    output logic c_o
);

    assign s_o = x_i ^ y_i ^ z_i;
    assign c_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);

endmodule

// File: rtl/mp_csa_row.sv
// One carry-save row: adds a sign-extended, shifted partial product into the
// (sum, carry) pair. The row of the operand sign bit adds the inverted
// multiplicand; its +1 is supplied by the seed row of the carry vector.
module mp_csa_row #(
    parameter int unsigned W   = 8,
    parameter int unsigned ROW = 1
) (
    input  logic [W-1:0]   a_i,
    input  logic           bsel_i,
    input  logic [2*W-1:0] sum_i,
    input  logic [2*W-1:0] car_i,
    output logic [2*W-1:0] sum_o,
    output logic [2*W-1:0] car_o
);

    localparam int unsigned P   = 2 * W;
    localparam bit          NEG = (ROW == W - 1);

    logic [P-1:0] aext;
    logic [P-1:0] pp;
    logic [P-2:0] cout;

    assign aext = {{W{a_i[W-1]}}, a_i};

    generate
        if (NEG) begin : g_neg_row
            assign pp = bsel_i ? ((~aext) << ROW) : '0;
        end else begin : g_pos_row
            assign pp = bsel_i ? (aext << ROW) : '0;
        end
    endgenerate

    generate
        for (genvar j = 0; j < P; j++) begin : g_bit
            if (j < P - 1) begin : g_full
                mp_fa_cell u_fa (
                    .x_i (sum_i[j]),
                    .y_i (car_i[j]),
                    .z_i (pp[j]),
                    .s_o (sum_o[j]),
                    .c_o (cout[j])
                );
            end else begin : g_msb
                // carry out of the top column falls outside the product
                assign sum_o[j] = sum_i[j] ^ car_i[j] ^ pp[j];
            end
        end
    endgenerate

    assign car_o = {cout, 1'b0};

endmodule

// File: rtl/mp_array_mult.sv
module mp_array_mult #(
    parameter int unsigned W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             in_valid_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    output logic             out_valid_o,
    output logic [2*W-1:0]   prod_o
);

    localparam int unsigned P    = 2 * W;
    localparam int unsigned ROWS = mp_pkg::mp_csa_rows(W);
    localparam int unsigned CPAS = mp_pkg::mp_cpa_stages(W);
    localparam int unsigned SKEW = ROWS - 1;

    typedef struct packed {
        logic         vld;
        logic [P-1:0] sum;
        logic [P-1:0] car;
    } csa_t;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } skew_t;

    typedef struct packed {
        logic         vld;
        logic [P-1:0] sum;
        logic [W-1:0] car_hi;
        logic         cy;
    } cpa_t;

    typedef struct packed {
        logic         vld;
        logic [P-1:0] prod;
    } out_t;

    csa_t  csa_d [ROWS];
    csa_t  csa_q [ROWS];
    skew_t sk_d  [SKEW];
    skew_t sk_q  [SKEW];
    cpa_t  cpa_d [CPAS];
    cpa_t  cpa_q [CPAS];
    out_t  out_d;
    out_t  out_q;

    // ---------------- seed row: partial product 0 and the sign-row +1
    logic [P-1:0] seed_sum;
    logic [P-1:0] seed_car;

    assign seed_sum = b_i[0]   ? {{W{a_i[W-1]}}, a_i} : '0;
    assign seed_car = b_i[W-1] ? (P'(1) << (W - 1))   : '0;

    // ---------------- carry-save rows
    logic [P-1:0] row_sum [ROWS];
    logic [P-1:0] row_car [ROWS];

    generate
        for (genvar r = 1; r <= ROWS; r++) begin : g_row
            if (r == 1) begin : g_first
                mp_csa_row #(.W(W), .ROW(r)) u_row (
                    .a_i    (a_i),
                    .bsel_i (b_i[r]),
                    .sum_i  (seed_sum),
                    .car_i  (seed_car),
                    .sum_o  (row_sum[r-1]),
                    .car_o  (row_car[r-1])
                );
            end else begin : g_next
                mp_csa_row #(.W(W), .ROW(r)) u_row (
                    .a_i    (sk_q[r-2].a),
                    .bsel_i (sk_q[r-2].b[r]),
                    .sum_i  (csa_q[r-2].sum),
                    .car_i  (csa_q[r-2].car),
                    .sum_o  (row_sum[r-1]),
                    .car_o  (row_car[r-1])
                );
            end
        end
    endgenerate

    // ---------------- carry-propagate chain, one cell per stage
    logic cp_x [CPAS];
    logic cp_y [CPAS];
    logic cp_z [CPAS];
    logic cp_s [CPAS];
    logic cp_c [CPAS];

    generate
        for (genvar k = 0; k < CPAS; k++) begin : g_cpa
            if (k == 0) begin : g_in_first
                assign cp_x[k] = csa_q[ROWS-1].sum[W];
                assign cp_y[k] = csa_q[ROWS-1].car[W];
                assign cp_z[k] = 1'b0;
            end else begin : g_in_next
                assign cp_x[k] = cpa_q[k-1].sum[W+k];
                assign cp_y[k] = cpa_q[k-1].car_hi[k];
                assign cp_z[k] = cpa_q[k-1].cy;
            end
            if (k < CPAS - 1) begin : g_cell
                mp_fa_cell u_fa (
                    .x_i (cp_x[k]),
                    .y_i (cp_y[k]),
                    .z_i (cp_z[k]),
                    .s_o (cp_s[k]),
                    .c_o (cp_c[k])
                );
            end else begin : g_msb
                assign cp_s[k] = cp_x[k] ^ cp_y[k] ^ cp_z[k];
                assign cp_c[k] = 1'b0;
            end
        end
    endgenerate

    // ---------------- next-state computation
    always_comb begin
        csa_d[0].vld = in_valid_i;
        csa_d[0].sum = row_sum[0];
        csa_d[0].car = row_car[0];
        for (int r = 1; r < ROWS; r++) begin
            csa_d[r].vld = csa_q[r-1].vld;
            csa_d[r].sum = row_sum[r];
            csa_d[r].car = row_car[r];
        end

        sk_d[0].a = a_i;
        sk_d[0].b = b_i;
        for (int s = 1; s < SKEW; s++) begin
            sk_d[s] = sk_q[s-1];
        end

        cpa_d[0].vld       = csa_q[ROWS-1].vld;
        cpa_d[0].sum       = csa_q[ROWS-1].sum;
        cpa_d[0].sum[W]    = cp_s[0];
        cpa_d[0].car_hi    = csa_q[ROWS-1].car[P-1:W];
        cpa_d[0].cy        = cp_c[0];
        for (int k = 1; k < CPAS; k++) begin
            cpa_d[k].vld      = cpa_q[k-1].vld;
            cpa_d[k].sum      = cpa_q[k-1].sum;
            cpa_d[k].sum[W+k] = cp_s[k];
            cpa_d[k].car_hi   = cpa_q[k-1].car_hi;
            cpa_d[k].cy       = cp_c[k];
        end

        out_d.vld  = cpa_q[CPAS-1].vld;
        out_d.prod = cpa_q[CPAS-1].sum;
    end

    // ---------------- state registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            csa_q <= '{default: '0};
            sk_q  <= '{default: '0};
            cpa_q <= '{default: '0};
            out_q <= '0;
        end else begin
            csa_q <= csa_d;
            sk_q  <= sk_d;
            cpa_q <= cpa_d;
            out_q <= out_d;
        end
    end

    assign out_valid_o = out_q.vld;
    assign prod_o      = out_q.prod;

endmodule

// File: rtl/mp_array_mult_chk.sv
module mp_array_mult_chk #(
    parameter int unsigned W = 8
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           in_valid_i,
    input logic [W-1:0]   a_i,
    input logic [W-1:0]   b_i,
    input logic           out_valid_o,
    input logic [2*W-1:0] prod_o
);

    localparam int unsigned P   = 2 * W;
    localparam int unsigned LAT = mp_pkg::mp_latency(W);

    logic                 armed_q = 1'b0;
    int unsigned          run_q   = 0;
    logic [LAT-1:0]       vdly_q  = '0;
    logic [P-1:0]         pdly_q [LAT];
    logic signed [P-1:0]  model;

    assign model = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});

    always_ff @(posedge clk_i) begin
        armed_q <= 1'b1;
        if (rst_i) begin
            run_q  <= 0;
            vdly_q <= '0;
        end else begin
            if (run_q < LAT) run_q <= run_q + 1;
            vdly_q <= {vdly_q[LAT-2:0], in_valid_i};
        end
        pdly_q[0] <= model;
        for (int k = 1; k < LAT; k++) pdly_q[k] <= pdly_q[k-1];
    end

    // R5: the edge after a reset edge sees a cleared output
    a_r5_reset_clear: assert property (@(posedge clk_i)
        (armed_q && $past(rst_i)) |-> (!out_valid_o && prod_o == '0));

    // R2 and R7: nothing sampled before the last reset ever emerges
    a_r2_quiet_window: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q < LAT) |-> !out_valid_o);

    // R3: output valid is the input valid delayed by the pipeline depth
    a_r3_valid_delay: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q == LAT) |-> (out_valid_o == vdly_q[LAT-1]));

    // R1: each valid output carries the signed product of its pair
    a_r1_product: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q == LAT && out_valid_o) |-> (prod_o == pdly_q[LAT-1]));

endmodule

bind mp_array_mult mp_array_mult_chk #(.W(W)) u_chk (.*);

// File: tb/mp_array_mult_tb.sv
`timescale 1ns/1ps
module mp_array_mult_tb;

    localparam int W   = 8;
    localparam int P   = 2 * W;
    localparam int LAT = 2 * W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         out_valid;
    logic [P-1:0] prod;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    bit           hv   [64];
    bit           hz   [64];
    logic [P-1:0] hp   [64];
    string        hreq [64];

    always #4 clk = ~clk;

    mp_array_mult #(.W(W)) u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .in_valid_i  (in_valid),
        .a_i         (a_in),
        .b_i         (b_in),
        .out_valid_o (out_valid),
        .prod_o      (prod)
    );

    function automatic logic [P-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        int sa;
        int sb;
        int pr;
        sa = a[W-1] ? int'(a) - (1 << W) : int'(a);
        sb = b[W-1] ? int'(b) - (1 << W) : int'(b);
        pr = sa * sb;
        return pr[P-1:0];
    endfunction

    // One cycle: check what the output shows now, then drive the next inputs.
    task automatic step(input bit r, input bit v, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string tag);
        int idx;
        @(negedge clk);
        idx = (cyc + 64 - LAT) % 64;
        total++;
        if (out_valid !== hv[idx]) begin
            bad++;
            $display("FAIL R3 (%s) cycle %0d: out_valid=%0b expected %0b",
                     hreq[idx], cyc, out_valid, hv[idx]);
        end
        if (hv[idx]) begin
            total++;
            if (prod !== hp[idx]) begin
                bad++;
                $display("FAIL %s cycle %0d: prod=%h expected %h", hreq[idx], cyc, prod, hp[idx]);
            end
        end else if (hz[idx]) begin
            total++;
            if (prod !== '0) begin
                bad++;
                $display("FAIL %s cycle %0d: prod=%h expected 0", hreq[idx], cyc, prod);
            end
        end
        rst      = r;
        in_valid = v;
        a_in     = a;
        b_in     = b;
        if (r) begin
            for (int k = 0; k < LAT; k++) begin
                if (cyc - k >= 0) begin
                    hv[(cyc-k)%64]   = 1'b0;
                    hz[(cyc-k)%64]   = 1'b1;
                    hreq[(cyc-k)%64] = tag;
                end
            end
        end else begin
            hv[cyc%64]   = v;
            hz[cyc%64]   = 1'b0;
            hp[cyc%64]   = ref_mul(a, b);
            hreq[cyc%64] = tag;
        end
        cyc++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish (got hang, expected completion)");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            hv[i] = 1'b0; hz[i] = 1'b1; hp[i] = '0; hreq[i] = "R5";
        end
        void'($urandom(32'd20240611));

        // R5: reset state, outputs stay clear until fresh data emerges
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'h55, 8'hAA, "R5");
        idle(LAT + 2, "R5");

        // R2: single isolated pulse, checked every cycle around its arrival
        step(1'b0, 1'b1, 8'd13, 8'd11, "R2");
        idle(LAT + 3, "R2");

        // R6: extreme operand pairs, streamed back to back
        step(1'b0, 1'b1, 8'h80, 8'h80, "R6");
        step(1'b0, 1'b1, 8'h80, 8'h7F, "R6");
        step(1'b0, 1'b1, 8'h7F, 8'h80, "R6");
        step(1'b0, 1'b1, 8'hFF, 8'hFF, "R6");
        step(1'b0, 1'b1, 8'h7F, 8'h7F, "R6");
        step(1'b0, 1'b1, 8'h00, 8'h80, "R6");
        step(1'b0, 1'b1, 8'h80, 8'h00, "R6");
        step(1'b0, 1'b1, 8'h01, 8'hFF, "R6");
        idle(LAT + 2, "R6");

        // R4: continuous random stream, no gaps
        for (int i = 0; i < 200; i++)
            step(1'b0, 1'b1, W'($urandom), W'($urandom), "R4");

        // R1: random stream with random gaps, inputs also toggle when idle
        for (int i = 0; i < 300; i++)
            step(1'b0, ($urandom % 4) != 0, W'($urandom), W'($urandom), "R1");
        idle(LAT + 2, "R1");

        // R7: full pipeline flushed by a two-cycle reset, then restart at once
        for (int i = 0; i < LAT + 4; i++)
            step(1'b0, 1'b1, W'($urandom), W'($urandom), "R7");
        step(1'b1, 1'b1, 8'h80, 8'h80, "R7");
        step(1'b1, 1'b1, 8'h7F, 8'h81, "R7");
        for (int i = 0; i < 40; i++)
            step(1'b0, ($urandom % 2) != 0, W'($urandom), W'($urandom), "R7");
        idle(LAT + 2, "R7");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule